// File: doc/BRIEF.md
# Single-Bit Memory Bus Access Sequencer

This block sits on the host side of a byte-addressed nonvolatile memory whose only data path is one bidirectional bit. The memory is driven by three active-low strobes: chip enable, output enable and write enable. The host issues one of three commands through a valid/ready handshake: read a run of bytes from an address, load and commit a page of bytes at an address, or poll for the end of an internal write. The sequencer turns each command into the series of single-bit bus cycles the memory expects. It supplies write bytes from a byte input and returns read bytes one at a time.

Every bus cycle has a strobe-low window of `LOW_CLKS` system clocks. This is followed by at least `HIGH_CLKS` clocks with all strobes high. In a write cycle, chip enable and write enable go low, and the bit on the data pin is held from the start of the cycle until the cycle has fully ended. In a read cycle, chip enable and output enable go low, and the pin is sampled in the last clock of the low window. A command that would wrap inside a page, or that asks for nothing, is refused without touching the bus.

Top module: `serbus_seq`

## Requirements
- R1: A read or page-write command starts with a three-cycle preamble: a read cycle, then a write cycle carrying 0, then a read cycle.
- R2: A write cycle drives ce_n=0, we_n=0, oe_n=1. A read cycle drives ce_n=0, oe_n=0, we_n=1. we_n and oe_n are never low together. Between cycles all three strobes are 1.
- R3: After the preamble, the 16 address bits go out as 16 write cycles, bit 15 first.
- R4: A read of N bytes (cmd_op=0, N=cmd_len) issues 8·N read cycles. Each group of 8 sampled bits, first bit as bit 7, is returned on rd_data with a one-clock rd_valid pulse, in address order.
- R5: A read command ends with one write cycle carrying 0, after its last read cycle.
- R6: A page write of N bytes (cmd_op=1) sends 8·N write cycles, MSB first. Each byte is taken from wr_data in the clock that its first bit's cycle starts. wr_take pulses for one clock in the clock after each byte is taken, so wr_data may then move to the next byte.
- R7: A command is refused when cmd_op=3, when cmd_len=0 for a read or write, or when a write has (cmd_addr mod 32)+cmd_len > 32. A refused command raises cmd_err together with cmd_done in the clock right after acceptance, and no bus cycle occurs.
- R8: A page write ends with a read cycle, a write cycle carrying 1, and a read cycle, which starts the internal write.
- R9: A poll (cmd_op=2) issues read cycles with no preamble until a sampled bit is 1, then completes.
- R10: Each strobe-low window lasts exactly LOW_CLKS clocks, and consecutive cycles are separated by at least HIGH_CLKS clocks of all strobes high.
- R11: mem_io_oe is 1 only during write cycles, from their start until the end of their high time. mem_io_out does not change when we_n rises.
- R12: cmd_ready is 1 only when idle, and the bus is quiet then. cmd_done is a single-clock pulse that ends every command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle, command accepted when valid |
| cmd_op | input | 2 | 0 read, 1 page write, 2 poll, 3 refused |
| cmd_addr | input | 16 | Start byte address |
| cmd_len | input | 6 | Byte count |
| wr_data | input | 8 | Next byte to write |
| wr_take | output | 1 | Pulse: the presented byte has been taken |
| rd_data | output | 8 | Byte read back |
| rd_valid | output | 1 | Pulse: rd_data holds a new byte |
| cmd_done | output | 1 | Pulse: command finished |
| cmd_err | output | 1 | With cmd_done: command refused |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_io_out | output | 1 | Bit driven onto the data pin |
| mem_io_oe | output | 1 | Drive enable for the data pin |
| mem_io_in | input | 1 | Bit sampled from the data pin |

## Verification
Reads of one to three bytes are issued from addresses of all zeros, all ones and a mixed pattern. These separate the MSB-first address order and show whether the per-byte regrouping of sampled bits lands on the right byte boundaries. Page writes are tried at the start of a page, ending exactly on the last byte of a page, and with a full 32-byte page; refusals are tried at one byte past the page end and with zero length. Together these tell a correct boundary comparison apart from an off-by-one. Polls with a busy time of zero, one and four reads show that completion follows the first sampled 1 and not a fixed count.

// File: rtl/serbus_seq.sv
module serbus_seq #(
  parameter int LOW_CLKS   = 13,
  parameter int HIGH_CLKS  = 17,
  parameter int PAGE_BYTES = 32,
  parameter int ADDR_W     = 16,
  parameter int LEN_W      = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic [7:0]        wr_data,
  output logic              wr_take,
  output logic [7:0]        rd_data,
  output logic              rd_valid,
  output logic              cmd_done,
  output logic              cmd_err,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              mem_io_out,
  output logic              mem_io_oe,
  input  logic              mem_io_in
);
  localparam int PW   = $clog2(PAGE_BYTES);
  localparam int CW   = LEN_W + 3;
  localparam int SW   = LEN_W + PW + 1;
  localparam int TMAX = (LOW_CLKS > HIGH_CLKS) ? LOW_CLKS : HIGH_CLKS;
  localparam int TW   = $clog2(TMAX + 1);
  localparam logic [1:0] OP_RD = 2'd0, OP_WR = 2'd1, OP_POLL = 2'd2;

  typedef enum logic [3:0] {S_IDLE, S_RST, S_ADDR, S_RD, S_RDEND, S_WR, S_WST, S_POLL, S_DONE} st_t;
  typedef enum logic [1:0] {P_IDLE, P_LOW, P_HIGH} ph_t;

  st_t              st;
  ph_t              ph;
  logic [1:0]       op_q;
  logic [LEN_W-1:0] len_q;
  logic [ADDR_W-1:0] addr_q;
  logic             err_q;
  logic [CW-1:0]    cnt;
  logic [TW-1:0]    tcnt;
  logic             cyc_wr, cyc_bit;
  logic [7:0]       wsh, rsh;
  logic             nx_wr, nx_bit, last_rw, reject, seq_busy;
  logic [SW-1:0]    span;

  assign span     = SW'(cmd_addr[PW-1:0]) + SW'(cmd_len);
  assign reject   = (cmd_op == 2'd3) || (cmd_op != OP_POLL && cmd_len == '0) ||
                    (cmd_op == OP_WR && span > SW'(PAGE_BYTES));
  assign last_rw  = (cnt == {len_q - LEN_W'(1), 3'b111});
  assign seq_busy = (st != S_IDLE) && (st != S_DONE);

  always_comb begin
    nx_wr  = 1'b0;
    nx_bit = 1'b0;
    case (st)
      S_RST:   nx_wr = (cnt[1:0] == 2'd1);
      S_ADDR:  begin nx_wr = 1'b1; nx_bit = addr_q[ADDR_W-1]; end
      S_RDEND: nx_wr = 1'b1;
      S_WR:    begin nx_wr = 1'b1; nx_bit = (cnt[2:0] == 3'd0) ? wr_data[7] : wsh[7]; end
      S_WST:   begin nx_wr = (cnt[1:0] == 2'd1); nx_bit = 1'b1; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= P_IDLE; op_q <= '0; len_q <= '0; addr_q <= '0;
      err_q <= 1'b0; cnt <= '0; tcnt <= '0; cyc_wr <= 1'b0; cyc_bit <= 1'b0;
      wsh <= '0; rsh <= '0; rd_data <= '0; rd_valid <= 1'b0; wr_take <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      wr_take  <= 1'b0;
      if (st == S_IDLE && cmd_valid) begin
        op_q <= cmd_op; len_q <= cmd_len; addr_q <= cmd_addr; err_q <= reject; cnt <= '0;
        st   <= reject ? S_DONE : ((cmd_op == OP_POLL) ? S_POLL : S_RST);
      end else if (st == S_DONE) begin
        st <= S_IDLE;
      end
      case (ph)
        P_IDLE: if (seq_busy) begin
          ph <= P_LOW; tcnt <= TW'(LOW_CLKS - 1); cyc_wr <= nx_wr; cyc_bit <= nx_bit;
          if (st == S_WR) begin
            wsh     <= (cnt[2:0] == 3'd0) ? {wr_data[6:0], 1'b0} : {wsh[6:0], 1'b0};
            wr_take <= (cnt[2:0] == 3'd0);
          end
        end
        P_LOW: if (tcnt == '0) begin
          ph <= P_HIGH; tcnt <= TW'(HIGH_CLKS - 1); rsh <= {rsh[6:0], mem_io_in};
        end else tcnt <= tcnt - 1'b1;
        default: if (tcnt == '0) begin
          ph <= P_IDLE;
          case (st)
            S_RST, S_WST: if (cnt == CW'(2)) begin
              st <= (st == S_RST) ? S_ADDR : S_DONE; cnt <= '0;
            end else cnt <= cnt + 1'b1;
            S_ADDR: begin
              addr_q <= addr_q << 1;
              if (cnt == CW'(ADDR_W - 1)) begin
                st <= (op_q == OP_RD) ? S_RD : S_WR; cnt <= '0;
              end else cnt <= cnt + 1'b1;
            end
            S_RD: begin
              if (cnt[2:0] == 3'd7) begin rd_valid <= 1'b1; rd_data <= rsh; end
              if (last_rw) begin st <= S_RDEND; cnt <= '0; end else cnt <= cnt + 1'b1;
            end
            S_RDEND: st <= S_DONE;
            S_WR: if (last_rw) begin st <= S_WST; cnt <= '0; end else cnt <= cnt + 1'b1;
            S_POLL: if (rsh[0]) st <= S_DONE;
            default: ;
          endcase
        end else tcnt <= tcnt - 1'b1;
      endcase
    end
  end

  assign mem_ce_n   = (ph != P_LOW);
  assign mem_we_n   = !(ph == P_LOW && cyc_wr);
  assign mem_oe_n   = !(ph == P_LOW && !cyc_wr);
  assign mem_io_oe  = (ph != P_IDLE) && cyc_wr;
  assign mem_io_out = cyc_bit;
  assign cmd_ready  = (st == S_IDLE);
  assign cmd_done   = (st == S_DONE);
  assign cmd_err    = cmd_done && err_q;

  logic [TW-1:0] low_run;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) low_run <= '0;
    else low_run <= mem_ce_n ? '0 : low_run + 1'b1;

  a_r10_low_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ce_n) |-> low_run == TW'(LOW_CLKS));
  a_r2_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_we_n && !mem_oe_n));
  a_r11_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_io_oe |-> mem_oe_n);
  a_r11_data_held_at_we_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> mem_io_oe && $stable(mem_io_out));
  a_r12_idle_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> mem_ce_n && !mem_io_oe);
  a_r12_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |=> !cmd_done);
  a_r7_refusal_immediate: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> $past(cmd_ready) && mem_ce_n);
endmodule

// File: tb/serbus_seq_tb_top.sv
module serbus_seq_tb_top;
  localparam int LOWC = 13;
  localparam int HIGHC = 17;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = '0;
  logic [15:0] cmd_addr = '0;
  logic [5:0] cmd_len = '0;
  logic [7:0] wr_data, rd_data;
  logic wr_take, rd_valid, cmd_ready, cmd_done, cmd_err;
  logic mem_ce_n, mem_oe_n, mem_we_n, mem_io_out, mem_io_oe, mem_io_in;

  always #2 clk = ~clk;

  serbus_seq dut_i (.clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_len(cmd_len), .wr_data(wr_data), .wr_take(wr_take),
    .rd_data(rd_data), .rd_valid(rd_valid), .cmd_done(cmd_done), .cmd_err(cmd_err),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_io_out(mem_io_out),
    .mem_io_oe(mem_io_oe), .mem_io_in(mem_io_in));

  int nchecks = 0, nfail = 0;
  int mode = 2, rcnt = 0, poll_busy = 0, widx = 0, n_rec = 0, n_exp = 0, n_got = 0;
  int tfail = 0, lo_len = 0, hi_len = 0, cycles = 0;
  logic [7:0] rbase = '0, wbase = '0;
  logic rec_w [0:1023];
  logic rec_b [0:1023];
  logic exp_w [0:1023];
  logic exp_b [0:1023];
  logic [7:0] got [0:63];
  logic prev_ce = 1'b1;
  logic [7:0] cur_rb;
  logic io_model;

  always_comb begin
    cur_rb = 8'((((rcnt - 2) / 8) * 29) + int'(rbase)) ^ 8'hA5;
    if (mode == 1) io_model = (rcnt >= poll_busy);
    else if (mode == 0 && rcnt >= 2) io_model = cur_rb[7 - ((rcnt - 2) % 8)];
    else io_model = 1'b0;
  end
  assign mem_io_in = io_model;
  assign wr_data = 8'((widx * 7) + int'(wbase)) ^ 8'h3C;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    nchecks++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
      $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
      $finish;
    end
    if (rst_n) begin
      if (!mem_ce_n && prev_ce) begin
        rec_w[n_rec] = !mem_we_n;
        rec_b[n_rec] = mem_io_out;
        if (mem_we_n == mem_oe_n) tfail++;
        if (mem_io_oe != !mem_we_n) tfail++;
        if (n_rec > 0 && hi_len < HIGHC) tfail++;
        n_rec++;
        lo_len = 1;
      end else if (!mem_ce_n) lo_len++;
      if (mem_ce_n && !prev_ce) begin
        if (lo_len != LOWC) tfail++;
        if (!rec_w[n_rec-1]) rcnt++;
        hi_len = 1;
      end else if (mem_ce_n) hi_len++;
      if (mem_ce_n && (!mem_we_n || !mem_oe_n)) tfail++;
      prev_ce = mem_ce_n;
      if (rd_valid) begin got[n_got] = rd_data; n_got++; end
      if (wr_take) widx++;
    end
  end

  task automatic push(input logic w, input logic b);
    exp_w[n_exp] = w; exp_b[n_exp] = b; n_exp++;
  endtask

  task automatic run(input int op, input int addr, input int len, input int busy);
    bit exp_err, got_err, seq_ok;
    int t, bad_at;
    logic [7:0] wb;
    logic [7:0] rb;
    exp_err = (op == 3) || (op != 2 && len == 0) || (op == 1 && ((addr % 32) + len) > 32);
    n_exp = 0;
    rbase = 8'(addr + len * 3);
    wbase = 8'(addr ^ (len * 11));
    if (!exp_err) begin
      if (op != 2) begin
        push(0, 0); push(1, 0); push(0, 0);
        for (int i = 15; i >= 0; i--) push(1, addr[i]);
      end
      if (op == 0) begin
        for (int i = 0; i < 8 * len; i++) push(0, 0);
        push(1, 0);
      end else if (op == 1) begin
        for (int k = 0; k < len; k++) begin
          wb = 8'((k * 7) + int'(wbase)) ^ 8'h3C;
          for (int i = 7; i >= 0; i--) push(1, wb[i]);
        end
        push(0, 0); push(1, 1); push(0, 0);
      end else begin
        for (int i = 0; i <= busy; i++) push(0, 0);
      end
    end
    while (!cmd_ready) @(negedge clk);
    mode = (op == 2) ? 1 : ((op == 0) ? 0 : 2);
    poll_busy = busy; n_rec = 0; rcnt = 0; n_got = 0; widx = 0; tfail = 0;
    cmd_valid = 1'b1; cmd_op = 2'(op); cmd_addr = 16'(addr); cmd_len = 6'(len);
    @(negedge clk);
    cmd_valid = 1'b0;
    t = 0;
    while (!cmd_done && t < 20000) begin @(negedge clk); t++; end
    chk(t < 20000, "R12 done pulse within time", t, 20000);
    got_err = cmd_err;
    @(negedge clk);
    chk(!cmd_done, "R12 done lasts one clock", int'(cmd_done), 0);
    chk(got_err == exp_err, "R7 refusal flag", int'(got_err), int'(exp_err));
    bad_at = -1;
    seq_ok = (n_rec == n_exp);
    for (int i = 0; i < n_exp && i < n_rec; i++)
      if (bad_at < 0 && (rec_w[i] != exp_w[i] || (exp_w[i] && rec_b[i] != exp_b[i]))) bad_at = i;
    if (bad_at >= 0) seq_ok = 0;
    if (op == 0) chk(seq_ok, "R1 R3 R4 R5 read cycle sequence", (bad_at >= 0) ? bad_at : n_rec, n_exp);
    else if (op == 1) chk(seq_ok, "R1 R3 R6 R8 write cycle sequence", (bad_at >= 0) ? bad_at : n_rec, n_exp);
    else chk(seq_ok, "R9 poll cycle sequence", (bad_at >= 0) ? bad_at : n_rec, n_exp);
    chk(tfail == 0, "R2 R10 R11 strobe shape and timing", tfail, 0);
    if (op == 0 && !exp_err) begin
      chk(n_got == len, "R4 byte count", n_got, len);
      for (int k = 0; k < len && k < n_got; k++) begin
        rb = 8'((k * 29) + int'(rbase)) ^ 8'hA5;
        chk(got[k] == rb, "R4 read byte value", int'(got[k]), int'(rb));
      end
    end
    if (op == 1 && !exp_err) chk(widx == len, "R6 bytes taken", widx, len);
    if (exp_err) chk(n_rec == 0, "R7 no bus cycle on refusal", n_rec, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready && mem_ce_n && mem_we_n && mem_oe_n && !mem_io_oe && !cmd_done,
        "R12 reset state idle and quiet", int'(cmd_ready), 1);
    for (int len = 1; len <= 3; len++) begin
      run(0, 16'h0000, len, 0);
      run(0, 16'hFFFF, len, 0);
      run(0, 16'hA5C3, len, 0);
    end
    run(0, 16'h0123, 0, 0);
    run(1, 16'h0000, 1, 0);
    run(1, 16'h1234, 12, 0);
    run(1, 16'h001F, 1, 0);
    run(1, 16'h0040, 32, 0);
    run(1, 16'h001F, 2, 0);
    run(1, 16'h001C, 5, 0);
    run(1, 16'h0100, 0, 0);
    run(3, 16'h0000, 4, 0);
    run(2, 16'h0000, 0, 0);
    run(2, 16'h0000, 0, 1);
    run(2, 16'h0000, 0, 4);
    $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    $finish;
  end
endmodule